// File: doc/BRIEF.md
# Suspend State Sequencer

This block moves a system into and out of its low-power states on command from software. Software first stores a suspend type in the control register, then sets the start bit in a second write. From then on the block works alone. It pulls a chain of five active-low outputs low, one at a time, in a fixed order. The chain is two status lines (one to the host bridge, one to other peripherals) followed by three power-plane controls, A, B and C. The chain stops at the depth that belongs to the chosen suspend type.

A wake input turns the sequence around. The outputs are released in exactly the reverse order, with the same spacing between steps. When the last output is released, the start bit clears itself. The spacing between steps comes from a delay register, and the block never uses less than a fixed minimum. A read port shows the stored type, the start bit, a busy flag, the current depth and the phase of the sequencer.

Top module: `susp_seq_ctrl`

## Requirements
- R1: After reset, all five outputs are high and the control register reads 0. The delay register reads the minimum delay, 16.
- R2: A control write (address 0) with bit 3 clear stores bits [2:0] as the suspend type. A control write with bit 3 set starts the sequence with the type already stored, and its bits [2:0] are not stored.
- R3: Type codes map to depths as follows: 0 (global standby) and 1 (stop-clock) reach depth 1, host status only. 2 (powered-on suspend) reaches depth 3, adding peripheral status and plane A. 3 (suspend-to-RAM) reaches depth 4, adding plane B. 4 (suspend-to-disk/off) reaches depth 5, adding plane C.
- R4: The host status goes low on the clock edge that accepts the start write. Each further output goes low D cycles after the one before it.
- R5: The outputs always form a prefix of the order host status, peripheral status, A, B, C. No output is low while one earlier in this order is high.
- R6: The step spacing D is the value written to the delay register (address 1), or 16 if that value is smaller. The delay register reads back the raw value that was written.
- R7: Wake is sampled high only while the sequence is entering or holding. The block then stops deepening at its current depth. D cycles after the wake edge it raises the deepest low output, and it keeps raising one output every D cycles.
- R8: The start bit (read bit 3) and the busy flag (read bit 4) stay set from the start until the last output is released. Both clear on that same edge.
- R9: Type codes 5, 6 and 7 are stored, but a start write while one of them is stored is ignored. All outputs stay high and the start bit stays 0.
- R10: Writes to either register are ignored while busy.
- R11: Control reads return type in [2:0], start in [3], busy in [4], depth in [7:5] and phase in [9:8] (0 idle, 1 entering, 2 holding, 3 exiting). Read data is registered, so it arrives one cycle after the address.
- R12: Wake while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 delay |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| wake | input | 1 | Resume request |
| stat_host_n | output | 1 | Active-low suspend status to the host bridge |
| stat_dev_n | output | 1 | Active-low suspend status to peripherals |
| plane_a_n | output | 1 | Active-low power-plane control A |
| plane_b_n | output | 1 | Active-low power-plane control B |
| plane_c_n | output | 1 | Active-low power-plane control C |

## Verification
The bench checks every output on every cycle of entry and exit against a depth it computes itself from the step spacing. A design that started one cycle late, counted D±1, or overshot the target depth would therefore show up on a single cycle.

It also targets these corner cases, and each one shows a distinct failure:
- A start write whose type field differs from the stored type: a design that took the type from this write would go too deep.
- An unused type code: a design that accepted it would pull the host line low.
- A delay below the minimum: a design that skipped the clamp would step too fast.
- Writes while holding: a design that accepted them would change the exit spacing or the readback.
- Wake in the middle of entry: a design that did not turn around would keep deepening.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  localparam int NUM_OUT = 5;
  localparam int LVL_W   = 3;
  localparam int TYPE_W  = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ENTER = 2'd1,
    PH_HOLD  = 2'd2,
    PH_EXIT  = 2'd3
  } phase_e;

  // depth reached by each suspend type; 0 marks an unused code
  function automatic logic [LVL_W-1:0] depth_of(input logic [TYPE_W-1:0] t);
    case (t)
      3'd0, 3'd1: depth_of = 3'd1;
      3'd2:       depth_of = 3'd3;
      3'd3:       depth_of = 3'd4;
      3'd4:       depth_of = 3'd5;
      default:    depth_of = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/ssq_regs.sv
module ssq_regs
  import ssq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DLY_W   = 16,
  parameter int DLY_MIN = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [LVL_W-1:0]  lvl,
  input  phase_e            phase,
  output logic              start,
  output logic [TYPE_W-1:0] type_q,
  output logic [DLY_W-1:0]  dly_eff
);
  localparam logic [DLY_W-1:0] MIN_V = DLY_W'(DLY_MIN);
  localparam int PAD_W = DATA_W - 10;

  logic [DLY_W-1:0] dly_q;
  logic             en_q;
  logic             wr_ok, wr_ctrl, wr_dly;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:4];
  assign wr_ok   = reg_we && !busy;
  assign wr_ctrl = wr_ok && (reg_addr == 1'b0);
  assign wr_dly  = wr_ok && (reg_addr == 1'b1);
  assign start   = wr_ctrl && reg_wdata[3] && (depth_of(type_q) != '0);
  assign dly_eff = (dly_q < MIN_V) ? MIN_V : dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= '0;
      dly_q  <= MIN_V;
      en_q   <= 1'b0;
    end else begin
      if (wr_ctrl && !reg_wdata[3]) type_q <= reg_wdata[TYPE_W-1:0];
      if (wr_dly) dly_q <= reg_wdata[DLY_W-1:0];
      if (start) en_q <= 1'b1;
      else if (done) en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_addr == 1'b0) begin
      reg_rdata <= {{PAD_W{1'b0}}, phase, lvl, busy, en_q, type_q};
    end else begin
      reg_rdata <= DATA_W'(dly_q);
    end
  end

  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_we && busy) |=> ($stable(type_q) && $stable(dly_q))); // R10
  AST_UNUSED_NO_START: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_addr && reg_wdata[3] && !busy && depth_of(type_q) == '0) |=> !en_q); // R9
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    done |=> (!en_q && !busy)); // R8
endmodule

// File: rtl/ssq_seq.sv
module ssq_seq
  import ssq_pkg::*;
#(
  parameter int DLY_W = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TYPE_W-1:0] type_sel,
  input  logic [DLY_W-1:0]  dly_eff,
  input  logic              wake,
  output logic              busy,
  output logic              done,
  output phase_e            phase_q,
  output logic [LVL_W-1:0]  lvl_q,
  output logic [LVL_W-1:0]  lvl_d
);
  phase_e           phase_d;
  logic [DLY_W-1:0] tmr_q, tmr_d;
  logic [LVL_W-1:0] tgt_q, tgt_d;

  assign busy = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    lvl_d   = lvl_q;
    tmr_d   = tmr_q;
    tgt_d   = tgt_q;
    done    = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          tgt_d   = depth_of(type_sel);
          lvl_d   = 3'd1;
          tmr_d   = dly_eff - 1'b1;
          phase_d = (depth_of(type_sel) == 3'd1) ? PH_HOLD : PH_ENTER;
        end
      end
      PH_ENTER: begin
        if (wake) begin
          phase_d = PH_EXIT;
          tmr_d   = dly_eff - 1'b1;
        end else if (tmr_q == '0) begin
          lvl_d = lvl_q + 1'b1;
          tmr_d = dly_eff - 1'b1;
          if (lvl_q + 1'b1 == tgt_q) phase_d = PH_HOLD;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (wake) begin
          phase_d = PH_EXIT;
          tmr_d   = dly_eff - 1'b1;
        end
      end
      PH_EXIT: begin
        if (tmr_q == '0) begin
          lvl_d = lvl_q - 1'b1;
          tmr_d = dly_eff - 1'b1;
          if (lvl_q == 3'd1) begin
            phase_d = PH_IDLE;
            done    = 1'b1;
          end
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      lvl_q   <= '0;
      tmr_q   <= '0;
      tgt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      lvl_q   <= lvl_d;
      tmr_q   <= tmr_d;
      tgt_q   <= tgt_d;
    end
  end

  AST_LVL_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(lvl_q) + 3'd1 || lvl_q == $past(lvl_q) - 3'd1)); // R4
  AST_EXIT_NO_DEEPEN: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXIT) |=> (lvl_q <= $past(lvl_q))); // R7
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |-> (lvl_q <= tgt_q && lvl_q != '0)); // R3
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !start) |=> (lvl_q == '0)); // R12
endmodule

// File: rtl/ssq_outdec.sv
module ssq_outdec
  import ssq_pkg::*;
#(
  parameter int N = NUM_OUT
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] lvl_d,
  output logic [N-1:0]     out_n
);
  for (genvar i = 0; i < N; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) out_n[i] <= 1'b1;
      else     out_n[i] <= !(32'(lvl_d) > i);
    end
    if (i > 0) begin : g_ord
      AST_PLANE_ORDER: assert property (@(posedge clk) disable iff (rst)
        !out_n[i] |-> !out_n[i-1]); // R5
    end
  end
endmodule

// File: rtl/susp_seq_ctrl.sv
module susp_seq_ctrl
  import ssq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DLY_W   = 16,
  parameter int DLY_MIN = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wake,
  output logic              stat_host_n,
  output logic              stat_dev_n,
  output logic              plane_a_n,
  output logic              plane_b_n,
  output logic              plane_c_n
);
  logic              busy, done, start;
  logic [TYPE_W-1:0] type_q;
  logic [DLY_W-1:0]  dly_eff;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  phase_e            phase_q;
  logic [NUM_OUT-1:0] out_n;

  ssq_regs #(.DATA_W(DATA_W), .DLY_W(DLY_W), .DLY_MIN(DLY_MIN)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .lvl(lvl_q), .phase(phase_q), .start(start), .type_q(type_q), .dly_eff(dly_eff)
  );

  ssq_seq #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .type_sel(type_q), .dly_eff(dly_eff),
    .wake(wake), .busy(busy), .done(done), .phase_q(phase_q),
    .lvl_q(lvl_q), .lvl_d(lvl_d)
  );

  ssq_outdec #(.N(NUM_OUT)) u_out (
    .clk(clk), .rst(rst), .lvl_d(lvl_d), .out_n(out_n)
  );

  assign stat_host_n = out_n[0];
  assign stat_dev_n  = out_n[1];
  assign plane_a_n   = out_n[2];
  assign plane_b_n   = out_n[3];
  assign plane_c_n   = out_n[4];
endmodule

// File: tb/susp_seq_ctrl_bench.sv
`timescale 1ns/1ps
module susp_seq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        wake = 1'b0;
  logic        stat_host_n, stat_dev_n, plane_a_n, plane_b_n, plane_c_n;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  susp_seq_ctrl u_susp_seq_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake(wake),
    .stat_host_n(stat_host_n), .stat_dev_n(stat_dev_n),
    .plane_a_n(plane_a_n), .plane_b_n(plane_b_n), .plane_c_n(plane_c_n)
  );

  // {type, depth}
  localparam logic [5:0] VEC [5] = '{
    {3'd0, 3'd1}, {3'd1, 3'd1}, {3'd2, 3'd3}, {3'd3, 3'd4}, {3'd4, 3'd5}
  };

  function automatic logic [4:0] pat(input int depth);
    logic [4:0] m;
    m = '0;
    for (int i = 0; i < 5; i++) if (i < depth) m[i] = 1'b1;
    return ~m;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input int depth);
    chk(tag, {11'd0, plane_c_n, plane_b_n, plane_a_n, stat_dev_n, stat_host_n},
        {11'd0, pat(depth)});
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  // k counted from the negedge after the accepting edge
  task automatic walk_enter(input string tag, input int tgt, input int d, input int n);
    for (int k = 0; k < n; k++) begin
      int e;
      e = 1 + k / d;
      if (e > tgt) e = tgt;
      chk_out(tag, e);
      @(negedge clk);
    end
  endtask

  // m counted from the negedge after the wake edge
  task automatic walk_exit(input string tag, input int from, input int d, input int n);
    for (int m = 0; m < n; m++) begin
      int e;
      e = from - m / d;
      if (e < 0) e = 0;
      chk_out(tag, e);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_out("R1 outputs", 0);
    rd(1'b0, r); chk("R1 ctrl", r, 16'd0);
    rd(1'b1, r); chk("R1 delay", r, 16'd16);

    // table walk: R3 R4 R7 R8 R11
    for (int i = 0; i < 5; i++) begin
      int t, tg;
      t = int'(VEC[i][5:3]);
      tg = int'(VEC[i][2:0]);
      wr(1'b0, 16'(t));
      wr(1'b0, 16'h0008);
      walk_enter("R3 R4 entry", tg, 16, tg * 16 + 4);
      rd(1'b0, r);
      chk("R8 R11 hold readback", r, 16'(t | 8 | 16 | (tg << 5) | (2 << 8)));
      pulse_wake();
      walk_exit("R7 exit", tg, 16, tg * 16 + 4);
      rd(1'b0, r);
      chk("R8 auto clear", r, 16'(t));
    end

    // R2 start write's type field is not used
    wr(1'b0, 16'h0000);
    wr(1'b0, 16'h000C);
    walk_enter("R2 stored type used", 1, 16, 40);
    rd(1'b0, r); chk("R2 type kept", {13'd0, r[2:0]}, 16'd0);
    pulse_wake();
    walk_exit("R2 exit", 1, 16, 20);

    // R9 unused code
    wr(1'b0, 16'h0006);
    wr(1'b0, 16'h0008);
    walk_exit("R9 no start", 0, 16, 20);
    rd(1'b0, r); chk("R9 ctrl", r, 16'h0006);

    // R12 wake while idle
    pulse_wake();
    walk_exit("R12 idle wake", 0, 16, 10);
    rd(1'b0, r); chk("R12 ctrl", r, 16'h0006);

    // R6 clamp of a short delay
    wr(1'b1, 16'd3);
    rd(1'b1, r); chk("R6 raw readback", r, 16'd3);
    wr(1'b0, 16'h0002);
    wr(1'b0, 16'h0008);
    walk_enter("R6 clamped spacing", 3, 16, 52);
    pulse_wake();
    walk_exit("R6 clamped exit", 3, 16, 52);

    // R6 longer delay, R10 writes while busy
    wr(1'b1, 16'd20);
    wr(1'b0, 16'h0004);
    wr(1'b0, 16'h0008);
    walk_enter("R6 spacing 20", 5, 20, 90);
    wr(1'b1, 16'd40);
    wr(1'b0, 16'h0001);
    rd(1'b1, r); chk("R10 delay kept", r, 16'd20);
    rd(1'b0, r); chk("R10 ctrl kept", r, 16'(4 | 8 | 16 | (5 << 5) | (2 << 8)));
    pulse_wake();
    walk_exit("R10 R7 exit spacing", 5, 20, 104);

    // R7 wake during entry
    wr(1'b1, 16'd16);
    wr(1'b0, 16'h0004);
    wr(1'b0, 16'h0008);
    walk_enter("R7 partial entry", 5, 16, 20);
    pulse_wake();
    walk_exit("R7 turn around", 2, 16, 40);
    rd(1'b0, r); chk("R7 R8 idle after", r, 16'h0004);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule